// File: doc/BRIEF.md
# Power-Down Clock Stop Controller

This block gates a bank of free-running source clocks in response to an active-low power-down request. The request is brought into the domain of a monitoring clock and qualified there. Once power-down is accepted, every gated output finishes its current high phase and then stays LOW. After all outputs report that they have stopped, the enables for the PLL, the crystal oscillator and the serial configuration port are dropped.

When the request returns HIGH, the rails come back first. The controller then waits for the PLL lock indication or for a programmable wake-up count, whichever comes first. Only then does it release the per-clock gates. Each gate opens while its source is LOW, so the first pulse on every output is a whole high phase. A ready flag reports that every output is running again.

Top module: `clkstop_ctrl`

## Requirements
- R1: While reset is held, every gated output is LOW and ready is 0. After reset the PLL, oscillator and configuration enables are 1, which is the wake-up wait state.
- R2: Power-down is accepted only when the request, after two synchronizer flops, is seen LOW on two consecutive rising edges of the monitoring clock. A request that is LOW for one monitoring edge only leaves the outputs toggling, ready at 1 and the enables at 1.
- R3: After acceptance, each gated output stops LOW at the end of its current high phase. No high phase on any output is ever shorter than the high phase of its source.
- R4: While powered down, every gated output is held LOW.
- R5: While powered down, the PLL, oscillator and configuration enables are all 0. They fall only after every lane has reported its output stopped.
- R6: On wake, each output restarts at a source rising edge, so the first pulse is a full high phase.
- R7: In the wake-up wait, the gates are released when the lock input is 1 or when the wake counter reaches `wake_limit`, whichever comes first. With no lock, ready does not appear before `wake_limit` monitoring cycles after the request returns HIGH.
- R8: Ready is 1 only while every lane reports its output running. It falls after power-down is accepted and stays 0 while powered down.
- R9: If acceptance and lock arrive in the same cycle of the wake-up wait, acceptance wins: the gates stay closed and the rails are dropped again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Monitoring clock; runs the qualifier and sequencer |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active LOW |
| src_clk | input | N_CLK | Free-running source clocks |
| pll_lock | input | 1 | Lock indication from the PLL |
| wake_limit | input | CNT_W | Wake-up wait bound, in monitoring cycles |
| gclk_out | output | N_CLK | Gated clocks |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| cfg_en | output | 1 | Serial configuration port enable |
| ready | output | 1 | All gated outputs running |

## Verification
Two functions can land in the same monitoring cycle: a fresh power-down acceptance and the lock arrival that would release the gates. The bench re-asserts the request just after the rails come up. It times the lock input so that lock becomes 1 on the very edge where the qualified request is first acted on. The bench judges that acceptance won: ready never rises, the PLL enable falls again, and all outputs stay LOW until the request is released.

// File: rtl/clkstop_pkg.sv
// Shared types for the power-down clock stop controller.
package clkstop_pkg;

    // Sequencer states; WAKE is the reset state
    typedef enum logic [1:0] {
        CS_WAKE = 2'd0,
        CS_RUN  = 2'd1,
        CS_STOP = 2'd2,
        CS_OFF  = 2'd3
    } cs_state_e;

endpackage

// File: rtl/clkstop_req_qual.sv
// Request qualifier.
// Synchronizes the asynchronous active-low power-down request into the
// monitoring-clock domain through SYNC_STAGES flops, then accepts it only
// when the synchronized level is LOW on two consecutive edges.
// Assumes: SYNC_STAGES >= 2; reset is synchronous to mon_clk.
module clkstop_req_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic mon_clk,
    input  logic rst_n,
    input  logic pd_req_n,
    output logic req_s,
    output logic accept
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchronizer chain, reset to the idle (HIGH) level
    always_ff @(posedge mon_clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pd_req_n};
    end

    // One-edge history of the synchronized request
    always_ff @(posedge mon_clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign req_s  = sync_q[SYNC_STAGES-1];
    assign accept = !req_s && !prev_q;

    // R2
    two_edge_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
        accept |-> (!$past(pd_req_n, SYNC_STAGES) && !$past(pd_req_n, SYNC_STAGES + 1)));

endmodule

// File: rtl/clkstop_seq.sv
// Power sequencer.
// Moves between wake-up wait, run, stopping and off. It drives the per-lane
// run enable, the shared rail enable (PLL, oscillator, configuration port)
// and the ready flag. The rails drop only after every lane reports
// stopped. Wake-up ends on lock or on counter expiry, whichever comes first.
// Assumes: ack_all/ack_any are already synchronized to mon_clk.
module clkstop_seq
    import clkstop_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             mon_clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             req_s,
    input  logic             pll_lock,
    input  logic [CNT_W-1:0] wake_limit,
    input  logic             ack_all,
    input  logic             ack_any,
    output logic             run_en,
    output logic             rail_en,
    output logic             ready,
    output logic             off_flag
);

    cs_state_e        st, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             run_q, rail_q, ready_q;

    // Next-state and wake-counter decode
    always_comb begin
        nxt     = st;
        cnt_nxt = cnt;
        unique case (st)
            CS_WAKE: begin
                if (accept)                              nxt = CS_STOP;
                else if (pll_lock || cnt >= wake_limit)  nxt = CS_RUN;
                else                                     cnt_nxt = cnt + 1'b1;
            end
            CS_RUN:  if (accept)   nxt = CS_STOP;
            CS_STOP: if (!ack_any) nxt = CS_OFF;
            CS_OFF: begin
                cnt_nxt = '0;
                if (req_s) nxt = CS_WAKE;
            end
            default: nxt = CS_WAKE;
        endcase
    end

    // State, counter and registered outputs
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            st      <= CS_WAKE;
            cnt     <= '0;
            run_q   <= 1'b0;
            rail_q  <= 1'b1;
            ready_q <= 1'b0;
        end else begin
            st      <= nxt;
            cnt     <= cnt_nxt;
            run_q   <= (nxt == CS_RUN);
            rail_q  <= (nxt != CS_OFF);
            ready_q <= (nxt == CS_RUN) && ack_all;
        end
    end

    assign run_en   = run_q;
    assign rail_en  = rail_q;
    assign ready    = ready_q;
    assign off_flag = (st == CS_OFF);

    // R5
    off_rails_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (st == CS_OFF) |-> !rail_q);

    // R5
    stop_order_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
        $rose(st == CS_OFF) |-> !$past(ack_any));

    // R7
    wake_expiry_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (st == CS_WAKE && cnt >= wake_limit && !accept) |=> (st == CS_RUN));

    // R9
    accept_wins_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (st == CS_WAKE && accept) |=> (st == CS_STOP));

endmodule

// File: rtl/clkstop_lane.sv
// One gated clock lane.
// The run enable is synchronized into the source domain. A latch that is
// transparent only while the source is LOW then holds it, so the AND gate
// can only start or end a pulse at a source edge. The latch state is
// synchronized back to mon_clk as the lane acknowledge.
// Assumes: the source clock runs during reset.
module clkstop_lane #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic mon_clk,
    input  logic rst_n,
    input  logic run_en,
    output logic gclk,
    output logic ack
);

    logic [SYNC_STAGES-1:0] en_sync;
    logic [SYNC_STAGES-1:0] ack_sync;
    logic                   gate_lat;

    // Bring the run enable into the source-clock domain
    always_ff @(posedge src_clk) begin
        if (!rst_n) en_sync <= '0;
        else        en_sync <= {en_sync[SYNC_STAGES-2:0], run_en};
    end

    // Gate latch: follows the enable only while the source is LOW
    always_latch begin
        if (!rst_n)        gate_lat = 1'b0;
        else if (!src_clk) gate_lat = en_sync[SYNC_STAGES-1];
    end

    assign gclk = src_clk & gate_lat;

    // Report the gate state back to the monitoring domain
    always_ff @(posedge mon_clk) begin
        if (!rst_n) ack_sync <= '0;
        else        ack_sync <= {ack_sync[SYNC_STAGES-2:0], gate_lat};
    end

    assign ack = ack_sync[SYNC_STAGES-1];

endmodule

// File: rtl/clkstop_ctrl.sv
// Power-down clock stop controller, top level.
// Qualifies the active-low request, sequences the rails, and gates N_CLK
// source clocks through glitch-free lanes.
// Assumes: rst_n is synchronous to mon_clk and held for several cycles of
// the slowest source clock.
module clkstop_ctrl #(
    parameter int N_CLK       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic             mon_clk,
    input  logic             rst_n,
    input  logic             pd_req_n,
    input  logic [N_CLK-1:0] src_clk,
    input  logic             pll_lock,
    input  logic [CNT_W-1:0] wake_limit,
    output logic [N_CLK-1:0] gclk_out,
    output logic             pll_en,
    output logic             osc_en,
    output logic             cfg_en,
    output logic             ready
);

    logic             req_s, accept;
    logic             run_en, rail_en, off_flag;
    logic [N_CLK-1:0] lane_ack;
    logic             ack_all, ack_any;

    clkstop_req_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
        .mon_clk  (mon_clk),
        .rst_n    (rst_n),
        .pd_req_n (pd_req_n),
        .req_s    (req_s),
        .accept   (accept)
    );

    clkstop_seq #(.CNT_W(CNT_W)) u_seq (
        .mon_clk    (mon_clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_s      (req_s),
        .pll_lock   (pll_lock),
        .wake_limit (wake_limit),
        .ack_all    (ack_all),
        .ack_any    (ack_any),
        .run_en     (run_en),
        .rail_en    (rail_en),
        .ready      (ready),
        .off_flag   (off_flag)
    );

    // One gated lane per source clock
    for (genvar i = 0; i < N_CLK; i++) begin : g_lane
        clkstop_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .src_clk (src_clk[i]),
            .mon_clk (mon_clk),
            .rst_n   (rst_n),
            .run_en  (run_en),
            .gclk    (gclk_out[i]),
            .ack     (lane_ack[i])
        );
    end

    assign ack_all = &lane_ack;
    assign ack_any = |lane_ack;

    assign pll_en = rail_en;
    assign osc_en = rail_en;
    assign cfg_en = rail_en;

    // R4
    off_low_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
        off_flag |-> (gclk_out == '0));

    // R8
    ready_ack_chk: assert property (@(posedge mon_clk) disable iff (!rst_n)
        ready |-> ack_all);

endmodule

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/1ps
module clkstop_ctrl_bench;

    localparam int N_CLK = 4;
    localparam int CNT_W = 16;
    localparam int LIMIT = 60;

    typedef struct packed {
        logic [7:0] low_cyc;
        logic [7:0] lock_dly;
        logic       exp_pd;
        logic [7:0] min_rdy;
        logic [7:0] max_rdy;
    } vec_t;

    // request-low length, lock delay after rails up, expect power-down, ready window
    localparam vec_t VECS [6] = '{
        '{8'd1,  8'd0, 1'b0, 8'd0,  8'd0},
        '{8'd2,  8'd4, 1'b1, 8'd0,  8'd35},
        '{8'd50, 8'd0, 1'b1, 8'd60, 8'd95},
        '{8'd1,  8'd0, 1'b0, 8'd0,  8'd0},
        '{8'd45, 8'd2, 1'b1, 8'd0,  8'd30},
        '{8'd3,  8'd0, 1'b1, 8'd60, 8'd95}
    };

    logic             mon_clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pd_req_n = 1'b1;
    logic [N_CLK-1:0] src_clk;
    logic             pll_lock = 1'b0;
    logic [CNT_W-1:0] wake_limit = CNT_W'(LIMIT);
    logic [N_CLK-1:0] gclk_out;
    logic             pll_en, osc_en, cfg_en, ready;

    int n_vec = 0;
    int n_bad = 0;
    int pd_cnt = 0;
    int rdrop_cnt = 0;
    int rrise_cnt = 0;
    int pos_total = 0;
    int pulses = 0;
    int short_pulses = 0;
    bit done = 1'b0;

    always #10 mon_clk = ~mon_clk;

    for (genvar i = 0; i < N_CLK; i++) begin : g_src
        localparam real HALF = 4.0 + 2.0 * i;
        logic s = 1'b0;
        real  t_rise = 0.0;
        always #(HALF) s = ~s;
        assign src_clk[i] = s;
        always @(posedge gclk_out[i]) begin
            t_rise = $realtime;
            pos_total++;
        end
        always @(negedge gclk_out[i]) begin
            pulses++;
            if (($realtime - t_rise) < HALF - 0.001 || ($realtime - t_rise) > HALF + 0.001)
                short_pulses++;
        end
    end

    always @(negedge pll_en) pd_cnt++;
    always @(negedge ready)  rdrop_cnt++;
    always @(posedge ready)  rrise_cnt++;

    clkstop_ctrl #(.N_CLK(N_CLK), .SYNC_STAGES(2), .CNT_W(CNT_W)) u_clkstop_ctrl (
        .mon_clk    (mon_clk),
        .rst_n      (rst_n),
        .pd_req_n   (pd_req_n),
        .src_clk    (src_clk),
        .pll_lock   (pll_lock),
        .wake_limit (wake_limit),
        .gclk_out   (gclk_out),
        .pll_en     (pll_en),
        .osc_en     (osc_en),
        .cfg_en     (cfg_en),
        .ready      (ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_all_low(input string req);
        int seen = 0;
        for (int k = 0; k < 6; k++) begin
            #3;
            seen = seen | int'(gclk_out);
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(20ns * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int n;
        int p0, r0, e0;
        // R1: reset state
        repeat (4) @(negedge mon_clk);
        chk_all_low("R1 outputs low in reset");
        chk(ready == 1'b0, "R1 ready in reset", int'(ready), 0);
        chk({pll_en, osc_en, cfg_en} == 3'b111, "R1 rails after reset",
            int'({pll_en, osc_en, cfg_en}), 7);
        @(negedge mon_clk);
        rst_n = 1'b1;

        // R7 R8: first wake with no lock ends by counter
        n = 0;
        while (!ready && n < 200) begin @(negedge mon_clk); n++; end
        chk(ready && n >= LIMIT && n <= LIMIT + 30, "R7 first wake by counter", n, LIMIT);
        e0 = pos_total;
        repeat (10) @(negedge mon_clk);
        chk(pos_total > e0 + 4 * N_CLK, "R8 outputs running when ready", pos_total - e0, 40);

        // Vector walk
        for (int v = 0; v < 6; v++) begin
            vec_t t;
            t = VECS[v];
            p0 = pd_cnt; r0 = rdrop_cnt; e0 = pos_total;
            pll_lock = 1'b0;
            pd_req_n = 1'b0;
            for (int c = 0; c < int'(t.low_cyc); c++) begin
                @(negedge mon_clk);
                if (c == 40) begin
                    chk_all_low("R4 outputs low while off");
                    chk({pll_en, osc_en, cfg_en} == 3'b000, "R5 rails off",
                        int'({pll_en, osc_en, cfg_en}), 0);
                    chk(ready == 1'b0, "R8 ready low while off", int'(ready), 0);
                end
            end
            pd_req_n = 1'b1;
            if (t.exp_pd) begin
                n = 0;
                while (pd_cnt == p0 && n < 200) begin @(negedge mon_clk); n++; end
                chk(pd_cnt != p0, "R2 request accepted", pd_cnt - p0, 1);
                while (!pll_en && n < 300) begin @(negedge mon_clk); n++; end
                if (t.lock_dly != 0) begin
                    for (int k = 0; k < int'(t.lock_dly); k++) begin @(negedge mon_clk); n++; end
                    pll_lock = 1'b1;
                end
                while (!ready && n < 300) begin @(negedge mon_clk); n++; end
                chk(ready && n >= int'(t.min_rdy) && n <= int'(t.max_rdy),
                    "R7 wake release window", n, int'(t.max_rdy));
            end else begin
                repeat (30) @(negedge mon_clk);
                chk(pd_cnt == p0, "R2 one-edge request ignored: rails", pd_cnt - p0, 0);
                chk(rdrop_cnt == r0, "R2 one-edge request ignored: ready", rdrop_cnt - r0, 0);
                chk(pos_total > e0 + 4 * N_CLK, "R2 one-edge request ignored: clocks",
                    pos_total - e0, 40);
            end
        end

        // R9: acceptance and lock arriving in the same wake cycle
        pll_lock = 1'b0;
        pd_req_n = 1'b0;
        repeat (20) @(negedge mon_clk);
        p0 = pd_cnt;
        pd_req_n = 1'b1;
        n = 0;
        while (!pll_en && n < 100) begin @(negedge mon_clk); n++; end
        r0 = rrise_cnt;
        pd_req_n = 1'b0;
        repeat (3) @(negedge mon_clk);
        pll_lock = 1'b1;
        repeat (30) @(negedge mon_clk);
        chk(rrise_cnt == r0, "R9 ready stays low", rrise_cnt - r0, 0);
        chk(pd_cnt == p0 + 1, "R9 rails dropped again", pd_cnt - p0, 1);
        chk_all_low("R9 outputs held low");
        pd_req_n = 1'b1;
        n = 0;
        while (!ready && n < 100) begin @(negedge mon_clk); n++; end
        chk(ready && n <= 30, "R7 lock already present at wake", n, 30);

        // R3 R6: every observed high phase matches its source
        repeat (10) @(negedge mon_clk);
        chk(pulses > 100, "R6 pulses observed", pulses, 100);
        chk(short_pulses == 0, "R3 R6 no truncated pulse", short_pulses, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule